// File: doc/BRIEF.md
# Bit-Test Instruction Decoder and Bus-Cycle Sequencer

This block takes a 16-bit opcode word of a 32-bit CISC processor and decides whether it is a bit-test instruction. There are two forms. In the dynamic form the bit number comes from a data register. In the static form the bit number comes from an extension word that follows the opcode. The block classifies the effective-address field and refuses any mode that this instruction cannot use. It also settles the operand width. A data-register destination is tested as a 32-bit value. A memory destination is tested as a single byte.

For an accepted opcode, the block plays out an ordered list of bus-cycle tokens, one at a time: program prefetch, data read or internal idle. A token is held until the consumer asserts `advance`. `done` is high together with the final token. Postincrement and predecrement modes produce a one-cycle pulse that asks an external address unit to adjust the address register by one. When the bit number and then the operand are presented, the block computes the zero flag. It writes back no other result. Address arithmetic, memory and the register file sit outside the block and connect through its ports.

Top module: `btst_seq`

## Requirements
- R1: An opcode with (opcode & 0xF1C0) == 0x0100 is the dynamic form. The cycle after it is accepted, `bit_reg` equals opcode[11:9].
- R2: An opcode with (opcode & 0xFFC0) == 0x0800 is the static form and is accepted with a legal mode.
- R3: The opcode is refused in three cases: it matches neither pattern, its mode field opcode[5:3] is 1, or its mode is 7 with opcode[2:0] of 4 or more. A refused opcode raises `illegal` for exactly one cycle, starting the cycle after `start`, and produces no token.
- R4: With mode 0 (data register destination), `size_long` is 1 and the bit number is taken modulo 32. The dynamic form emits prefetch, idle. The static form emits prefetch, prefetch, idle.
- R5: With any memory mode, `size_long` is 0 and the bit number is taken modulo 8.
- R6: Modes 2 and 3 emit read, prefetch. In mode 3, `areg_inc` pulses for one cycle, in the cycle after the read token is consumed.
- R7: Mode 4 emits idle, read, prefetch. `areg_dec` pulses for one cycle, in the cycle after the idle token is consumed.
- R8: Modes 5 and 6, and mode 7 with register 0, 2 or 3, emit prefetch, read, prefetch. Mode 7 with register 1 emits prefetch, prefetch, read, prefetch.
- R9: The static form emits one extra prefetch ahead of the sequence of the dynamic form.
- R10: Data is presented in two steps. First `bitsrc_vld` latches the bit number. Later `operand_vld` presents the operand, and one cycle after that `zero_flag` is 1 if the selected bit is 0 and 0 if it is 1. Without `operand_vld`, `zero_flag` keeps its value.
- R11: Token codes on `tok_kind` are 1 = prefetch, 2 = read, 3 = idle. A token stays on the outputs until `advance` is high at a clock edge. `done` is high only with the last token. `start` has no effect while a token is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Offers `opcode` for decode; taken only when no token is pending |
| opcode | input | 16 | Instruction word |
| advance | input | 1 | Consumes the current token |
| bitsrc_vld | input | 1 | Latches the bit number from `bitsrc_val` |
| bitsrc_val | input | DATA_W | Register value or extension word holding the bit number |
| operand_vld | input | 1 | Operand present; updates the zero flag |
| operand_val | input | DATA_W | Destination operand (register or read data) |
| illegal | output | 1 | One-cycle pulse for a refused opcode |
| size_long | output | 1 | 1 = 32-bit test, 0 = byte test |
| bit_reg | output | 3 | Data register index holding the bit number (dynamic form) |
| ea_code | output | 5 | Combined mode code: mode for modes 0-6, 0x10 plus register for mode 7 |
| ea_areg | output | 3 | Register field of the effective address |
| tok_valid | output | 1 | A token is pending |
| tok_kind | output | 2 | Current token: 1 prefetch, 2 read, 3 idle |
| done | output | 1 | Current token is the last one |
| areg_inc | output | 1 | Postincrement request pulse |
| areg_dec | output | 1 | Predecrement request pulse |
| zero_flag | output | 1 | Zero result of the bit test |

## Verification
The bench walks every 6-bit effective-address field. It does this in the dynamic form for all eight bit-number registers and once in the static form, and it adds a handful of opcodes that match neither pattern. The result separates the legal modes from the refused ones, and it checks the exact token order for each mode and form. Bit numbers grow well past 32, so a check passes only if the right modulus was applied: modulo 8 for memory and modulo 32 for a register. Operands vary from one test to the next, so both values of the zero flag occur. Some runs stall `advance`, which shows that a token is held. One run offers a new `start` in the middle of a sequence to confirm that it is ignored.

// File: rtl/btst_pkg.sv
package btst_pkg;
  localparam int TOK_W = 2;

  typedef enum logic [1:0] {
    TK_NONE   = 2'd0,
    TK_PFETCH = 2'd1,
    TK_READ   = 2'd2,
    TK_IDLE   = 2'd3
  } tok_e;

  // combined effective-address codes (mode 7 folds in the register field)
  localparam logic [4:0] EA_DREG = 5'h00;
  localparam logic [4:0] EA_IND  = 5'h02;
  localparam logic [4:0] EA_POST = 5'h03;
  localparam logic [4:0] EA_PRE  = 5'h04;
  localparam logic [4:0] EA_D16  = 5'h05;
  localparam logic [4:0] EA_IDX  = 5'h06;
  localparam logic [4:0] EA_ABSW = 5'h10;
  localparam logic [4:0] EA_ABSL = 5'h11;
  localparam logic [4:0] EA_PCD  = 5'h12;
  localparam logic [4:0] EA_PCI  = 5'h13;
endpackage

// File: rtl/btst_decode.sv
module btst_decode
  import btst_pkg::*;
#(
  parameter int MAX_TOK = 5,
  parameter int CNT_W   = $clog2(MAX_TOK + 1)
) (
  input  logic [15:0]              opcode,
  output logic                     legal,
  output logic                     long_op,
  output logic                     post_inc,
  output logic                     pre_dec,
  output logic [4:0]               ea_code,
  output logic [2:0]               bit_reg,
  output logic [MAX_TOK*TOK_W-1:0] seq,
  output logic [CNT_W-1:0]         seq_len
);
  localparam int SW = MAX_TOK * TOK_W;

  logic             is_dyn;
  logic             is_stat;
  logic             mode_ok;
  logic [SW-1:0]    base_seq;
  logic [CNT_W-1:0] base_len;

  always_comb begin
    is_dyn   = (opcode & 16'hF1C0) == 16'h0100;
    is_stat  = (opcode & 16'hFFC0) == 16'h0800;
    ea_code  = (opcode[5:3] == 3'd7) ? {2'b10, opcode[2:0]} : {2'b00, opcode[5:3]};
    mode_ok  = 1'b1;
    base_seq = '0;
    base_len = '0;
    // token 0 sits in the least significant slot
    case (ea_code)
      EA_DREG: begin
        base_seq = SW'({TK_IDLE, TK_PFETCH});
        base_len = CNT_W'(2);
      end
      EA_IND, EA_POST: begin
        base_seq = SW'({TK_PFETCH, TK_READ});
        base_len = CNT_W'(2);
      end
      EA_PRE: begin
        base_seq = SW'({TK_PFETCH, TK_READ, TK_IDLE});
        base_len = CNT_W'(3);
      end
      EA_D16, EA_IDX, EA_ABSW, EA_PCD, EA_PCI: begin
        base_seq = SW'({TK_PFETCH, TK_READ, TK_PFETCH});
        base_len = CNT_W'(3);
      end
      EA_ABSL: begin
        base_seq = SW'({TK_PFETCH, TK_READ, TK_PFETCH, TK_PFETCH});
        base_len = CNT_W'(4);
      end
      default: mode_ok = 1'b0;
    endcase

    legal    = (is_dyn | is_stat) & mode_ok;
    long_op  = (ea_code == EA_DREG);
    post_inc = (ea_code == EA_POST);
    pre_dec  = (ea_code == EA_PRE);
    bit_reg  = opcode[11:9];

    if (is_stat) begin
      // extension word fetch goes first
      seq     = {base_seq[SW-TOK_W-1:0], TK_PFETCH};
      seq_len = base_len + CNT_W'(1);
    end else begin
      seq     = base_seq;
      seq_len = base_len;
    end
  end
endmodule

// File: rtl/btst_token_seq.sv
module btst_token_seq
  import btst_pkg::*;
#(
  parameter int MAX_TOK = 5,
  parameter int CNT_W   = $clog2(MAX_TOK + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [MAX_TOK*TOK_W-1:0] ld_seq,
  input  logic [CNT_W-1:0]         ld_len,
  input  logic                     ld_post,
  input  logic                     ld_pre,
  input  logic                     advance,
  output logic                     tok_valid,
  output logic [TOK_W-1:0]         tok_kind,
  output logic                     done,
  output logic                     areg_inc,
  output logic                     areg_dec
);
  localparam int SW = MAX_TOK * TOK_W;

  logic [SW-1:0]    q;
  logic [CNT_W-1:0] rem;
  logic             post_r;
  logic             pre_r;

  assign tok_valid = (rem != '0);
  assign tok_kind  = q[TOK_W-1:0];
  assign done      = (rem == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      q        <= '0;
      rem      <= '0;
      post_r   <= 1'b0;
      pre_r    <= 1'b0;
      areg_inc <= 1'b0;
      areg_dec <= 1'b0;
    end else begin
      areg_inc <= 1'b0;
      areg_dec <= 1'b0;
      if (load) begin
        q      <= ld_seq;
        rem    <= ld_len;
        post_r <= ld_post;
        pre_r  <= ld_pre;
      end else if (tok_valid && advance) begin
        q        <= q >> TOK_W;
        rem      <= rem - CNT_W'(1);
        areg_inc <= post_r && (q[TOK_W-1:0] == TK_READ);
        areg_dec <= pre_r && (q[TOK_W-1:0] == TK_IDLE);
      end
    end
  end

  // R11
  tok_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && !advance) |=> (tok_valid && $stable(tok_kind)));
  // R11
  done_last_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> tok_valid);
  // R11
  seq_end_chk: assert property (@(posedge clk) disable iff (rst)
    (done && advance) |=> !tok_valid);
  // R11
  rem_range_chk: assert property (@(posedge clk) disable iff (rst)
    rem <= CNT_W'(MAX_TOK));
  // R6
  inc_single_chk: assert property (@(posedge clk) disable iff (rst)
    areg_inc |=> !areg_inc);
  // R7
  adj_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({areg_inc, areg_dec}));
endmodule

// File: rtl/btst_zero.sv
module btst_zero #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              load,
  input  logic              ld_long,
  input  logic              bsrc_vld,
  input  logic [DATA_W-1:0] bsrc_val,
  input  logic              opnd_vld,
  input  logic [DATA_W-1:0] opnd_val,
  output logic              zero_flag
);
  localparam int BN_W = $clog2(DATA_W);
  localparam int BB_W = $clog2(BYTE_W);
  localparam logic [DATA_W-1:0] MOD_L = DATA_W'(DATA_W);

  logic [BN_W-1:0] bitnum;
  logic [BN_W-1:0] sel;
  logic            long_r;

  always_comb begin
    sel = long_r ? bitnum : BN_W'(bitnum[BB_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitnum    <= '0;
      long_r    <= 1'b0;
      zero_flag <= 1'b0;
    end else begin
      if (load) long_r <= ld_long;
      if (active && bsrc_vld) bitnum <= BN_W'(bsrc_val % MOD_L);
      if (active && opnd_vld) zero_flag <= ~opnd_val[sel];
    end
  end

  // R10
  zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(active && opnd_vld) |=> $stable(zero_flag));
endmodule

// File: rtl/btst_seq.sv
module btst_seq
  import btst_pkg::*;
#(
  parameter int MAX_TOK = 5,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [15:0]       opcode,
  input  logic              advance,
  input  logic              bitsrc_vld,
  input  logic [DATA_W-1:0] bitsrc_val,
  input  logic              operand_vld,
  input  logic [DATA_W-1:0] operand_val,
  output logic              illegal,
  output logic              size_long,
  output logic [2:0]        bit_reg,
  output logic [4:0]        ea_code,
  output logic [2:0]        ea_areg,
  output logic              tok_valid,
  output logic [1:0]        tok_kind,
  output logic              done,
  output logic              areg_inc,
  output logic              areg_dec,
  output logic              zero_flag
);
  localparam int CNT_W = $clog2(MAX_TOK + 1);
  localparam int SW    = MAX_TOK * TOK_W;

  logic             d_legal;
  logic             d_long;
  logic             d_post;
  logic             d_pre;
  logic [4:0]       d_ea;
  logic [2:0]       d_breg;
  logic [SW-1:0]    d_seq;
  logic [CNT_W-1:0] d_len;
  logic             accept;
  logic             load;

  btst_decode #(.MAX_TOK(MAX_TOK), .CNT_W(CNT_W)) u_dec (
    .opcode  (opcode),
    .legal   (d_legal),
    .long_op (d_long),
    .post_inc(d_post),
    .pre_dec (d_pre),
    .ea_code (d_ea),
    .bit_reg (d_breg),
    .seq     (d_seq),
    .seq_len (d_len)
  );

  assign accept = start && !tok_valid;
  assign load   = accept && d_legal;

  btst_token_seq #(.MAX_TOK(MAX_TOK), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .ld_seq   (d_seq),
    .ld_len   (d_len),
    .ld_post  (d_post),
    .ld_pre   (d_pre),
    .advance  (advance),
    .tok_valid(tok_valid),
    .tok_kind (tok_kind),
    .done     (done),
    .areg_inc (areg_inc),
    .areg_dec (areg_dec)
  );

  btst_zero #(.DATA_W(DATA_W)) u_zero (
    .clk      (clk),
    .rst      (rst),
    .active   (tok_valid),
    .load     (load),
    .ld_long  (d_long),
    .bsrc_vld (bitsrc_vld),
    .bsrc_val (bitsrc_val),
    .opnd_vld (operand_vld),
    .opnd_val (operand_val),
    .zero_flag(zero_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      illegal   <= 1'b0;
      size_long <= 1'b0;
      bit_reg   <= '0;
      ea_code   <= '0;
      ea_areg   <= '0;
    end else begin
      illegal <= accept && !d_legal;
      if (load) begin
        size_long <= d_long;
        bit_reg   <= d_breg;
        ea_code   <= d_ea;
        ea_areg   <= opcode[2:0];
      end
    end
  end

  // R3
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !tok_valid);
  // R3
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (illegal && !start) |=> !illegal);
endmodule

// File: tb/btst_seq_test.sv
module btst_seq_test;
  localparam logic [1:0] PF = 2'd1, RD = 2'd2, ID = 2'd3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] opcode = '0;
  logic        advance = 1'b0;
  logic        bitsrc_vld = 1'b0;
  logic [31:0] bitsrc_val = '0;
  logic        operand_vld = 1'b0;
  logic [31:0] operand_val = '0;
  logic        illegal, size_long, tok_valid, done, areg_inc, areg_dec, zero_flag;
  logic [2:0]  bit_reg, ea_areg;
  logic [4:0]  ea_code;
  logic [1:0]  tok_kind;

  int n_tests = 0;
  int n_fail  = 0;
  int k       = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  btst_seq uut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .advance(advance),
    .bitsrc_vld(bitsrc_vld), .bitsrc_val(bitsrc_val),
    .operand_vld(operand_vld), .operand_val(operand_val),
    .illegal(illegal), .size_long(size_long), .bit_reg(bit_reg),
    .ea_code(ea_code), .ea_areg(ea_areg), .tok_valid(tok_valid),
    .tok_kind(tok_kind), .done(done), .areg_inc(areg_inc),
    .areg_dec(areg_dec), .zero_flag(zero_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit mode_ok(int code);
    return code inside {0, 2, 3, 4, 5, 6, 16, 17, 18, 19};
  endfunction

  function automatic logic [13:0] exp_list(bit stat, int code);
    logic [9:0] t = '0;
    int n = 0;
    if (stat) begin t[1:0] = PF; n = 1; end
    case (code)
      0: begin t[2*n +: 2] = PF; t[2*n+2 +: 2] = ID; n += 2; end
      2, 3: begin t[2*n +: 2] = RD; t[2*n+2 +: 2] = PF; n += 2; end
      4: begin t[2*n +: 2] = ID; t[2*n+2 +: 2] = RD; t[2*n+4 +: 2] = PF; n += 3; end
      17: begin
        t[2*n +: 2] = PF; t[2*n+2 +: 2] = PF; t[2*n+4 +: 2] = RD; t[2*n+6 +: 2] = PF; n += 4;
      end
      default: begin t[2*n +: 2] = PF; t[2*n+2 +: 2] = RD; t[2*n+4 +: 2] = PF; n += 3; end
    endcase
    return {n[3:0], t};
  endfunction

  function automatic string tag_for(int code, bit stat, int i);
    if (stat && i == 0) return "R9 lead prefetch";
    if (code == 0) return "R4 register sequence";
    if (code == 2 || code == 3) return "R6 indirect sequence";
    if (code == 4) return "R7 predecrement sequence";
    return "R8 displacement/absolute sequence";
  endfunction

  task automatic run_one(input logic [15:0] op, input bit stall);
    bit dyn, stat, legal;
    int code, n, b;
    logic [13:0] el;
    logic [31:0] bv, ov;
    bit zexp;
    dyn   = (op & 16'hF1C0) == 16'h0100;
    stat  = (op & 16'hFFC0) == 16'h0800;
    code  = (op[5:3] == 3'd7) ? 16 + int'(op[2:0]) : int'(op[5:3]);
    legal = (dyn || stat) && mode_ok(code);
    k++;
    bv = 32'(k * 13 + 5);
    ov = (32'h9E3779B9 * 32'(k)) ^ 32'h5A5A1234;

    @(negedge clk); opcode = op; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R3 illegal flag", illegal, !legal);
    if (!legal) begin
      chk("R3 no tokens", tok_valid, 0);
      @(negedge clk);
      chk("R3 single pulse", illegal, 0);
      chk("R3 still no tokens", tok_valid, 0);
      return;
    end
    if (stat) chk("R2 static form accepted", tok_valid, 1);
    else begin
      chk("R1 dynamic form accepted", tok_valid, 1);
      chk("R1 bit register index", bit_reg, op[11:9]);
    end
    if (code == 0) chk("R4 long size", size_long, 1);
    else chk("R5 byte size", size_long, 0);

    bitsrc_vld = 1'b1; bitsrc_val = bv;
    @(negedge clk); bitsrc_vld = 1'b0; operand_vld = 1'b1; operand_val = ov;
    @(negedge clk); operand_vld = 1'b0;
    b = (code == 0) ? int'(bv % 32) : int'(bv % 8);
    zexp = !ov[b];
    chk(code == 0 ? "R10 R4 zero mod 32" : "R10 R5 zero mod 8", zero_flag, zexp);

    el = exp_list(stat, code);
    n  = int'(el[13:10]);
    for (int i = 0; i < n; i++) begin
      logic [1:0] et;
      et = el[2*i +: 2];
      chk("R11 token pending", tok_valid, 1);
      chk(tag_for(code, stat, i), tok_kind, et);
      chk("R11 done with last token", done, (i == n - 1));
      if (stall && i == 0) begin
        @(negedge clk);
        chk("R11 token held without advance", tok_kind, et);
      end
      advance = 1'b1;
      @(negedge clk); advance = 1'b0;
      chk("R6 postincrement pulse", areg_inc, (code == 3 && et == RD));
      chk("R7 predecrement pulse", areg_dec, (code == 4 && et == ID));
    end
    chk("R11 sequence ended", tok_valid, 0);
    chk("R10 zero held", zero_flag, zexp);
  endtask

  initial begin
    #(8 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    if (!finished) $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset no token", tok_valid, 0);
    chk("R3 reset illegal low", illegal, 0);
    chk("R11 reset done low", done, 0);
    chk("R10 reset zero low", zero_flag, 0);

    for (int r = 0; r < 8; r++)
      for (int ea = 0; ea < 64; ea++)
        run_one(16'h0100 | 16'(r << 9) | 16'(ea), (ea % 5) == 0);
    for (int ea = 0; ea < 64; ea++)
      run_one(16'h0800 | 16'(ea), (ea % 3) == 0);
    run_one(16'h0000, 1'b0);
    run_one(16'h0140, 1'b0);
    run_one(16'h0840, 1'b0);
    run_one(16'hFFFF, 1'b0);
    run_one(16'h4E71, 1'b0);
    run_one(16'h0A10, 1'b0);

    // R11: start while busy is ignored
    @(negedge clk); opcode = 16'h0810; start = 1'b1;
    @(negedge clk); opcode = 16'hFFFF;
    chk("R11 busy start first token", tok_kind, PF);
    @(negedge clk); start = 1'b0;
    chk("R11 busy start not flagged", illegal, 0);
    chk("R11 busy start token kept", tok_kind, PF);
    chk("R11 busy start still pending", tok_valid, 1);
    for (int i = 0; i < 3; i++) begin
      chk("R11 busy start sequence", tok_kind, (i == 1) ? RD : PF);
      advance = 1'b1;
      @(negedge clk); advance = 1'b0;
    end
    chk("R11 busy start ended", tok_valid, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule